// File: doc/BRIEF.md
# Programmable Event Counter Bank

The block holds a bank of general-purpose event counters, each steered by its own 32-bit selection register, plus one free-running 64-bit timestamp. Every cycle the surrounding logic presents a vector of event strobes, a small sub-event bus per event, and the current privilege level. Each counter picks one event by code, qualifies it by sub-event mask, privilege, threshold, inversion and edge detection, and adds the result to its 48-bit count.

Sampling works by preloading a counter with 2^48 minus the wanted period. When the count wraps past the top of its range and interrupts are enabled for that counter, a per-counter pending bit is set. The interrupt line stays high while any pending bit is set. Software clears pending bits one at a time by writing ones to the status register. All state is reached through a flat register port. Reads are combinational and writes take effect at the next clock edge.

Register map (word addresses): 0 timestamp, 1..4 counters 0..3, 5..8 selection registers 0..3, 9 pending status.

Top module: `evt_counter_bank`

## Requirements
- R1: The timestamp at address 0 reads 0 right after reset and rises by exactly one every clock. Writes to address 0 have no effect.
- R2: A counter changes only while bit 22 (enable) of its selection register is set. Clearing that bit freezes the count, and the held value stays readable.
- R3: Bits [7:0] of the selection register pick event input number `code`. A code at or above the number of event inputs counts nothing, and strobes on other event inputs are never counted.
- R4: If the unit mask in bits [15:8] is zero, the per-cycle event count is 1 when the selected strobe is high and 0 otherwise. If the mask is nonzero, the count is the number of set bits in (sub-event bus AND mask), and the strobe is not used.
- R5: Bit 16 allows counting while `priv_user` is 1. Bit 17 allows counting while it is 0. With both bits clear, nothing is counted.
- R6: With a zero threshold in bits [31:24], the counter adds the per-cycle count. With a nonzero threshold, it adds 1 on cycles where the count is at least the threshold, or, when bit 23 (invert) is set, on cycles where it is below the threshold. Invert has no effect when the threshold is zero.
- R7: With bit 18 (edge) set, the counter adds 1 only on a cycle where the qualified condition is true and was false in the previous cycle.
- R8: A counter wraps modulo 2^48. A wrap sets that counter's bit in the status register (address 9, bit i for counter i) only if bit 20 (interrupt enable) is set.
- R9: `irq` is high while any status bit is set. Writing a 1 to a status bit clears only that bit. A wrap in the same cycle as the clear of the same bit leaves the bit set.
- R10: After a counter is preloaded with 2^48−N, `irq` is first seen high right after the clock edge that takes in the N-th qualified event, and not before.
- R11: After reset, all counters, selection registers and status bits read 0, and `irq` is low.
- R12: A write to a counter takes effect at the next edge and overrides any event counted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| evt_fire | input | 8 | Per-event strobe for this cycle |
| evt_sub | input | 64 | Sub-event bits, 8 per event, event i at [8i+7:8i] |
| priv_user | input | 1 | 1 = user level, 0 = kernel level |
| irq | output | 1 | Any overflow pending |

## Verification
Two things can happen in one cycle. A counter may wrap and set its pending bit while software writes a one to clear that same bit. A counter may also be written by software while a qualified event arrives. The bench provokes both cases directly. It preloads a counter with all ones and, on the same negative edge, raises the event strobe and presents a status clear (or a counter write). It then judges by reading the register back after the edge. The pending bit must survive, and the written value must appear unchanged by the event.

// File: rtl/evb_pkg.sv
// Shared types for the event counter bank.
// Assumes a fixed 32-bit selection register with 8-bit mask and threshold.
package evb_pkg;
    localparam int SEL_W   = 32;
    localparam int UMASK_W = 8;
    localparam int THR_W   = 8;

    // Selection register layout, MSB first.
    typedef struct packed {
        logic [THR_W-1:0]   thresh;     // 31:24
        logic               invert;     // 23
        logic               enable;     // 22
        logic               rsv21;      // 21
        logic               irq_en;     // 20
        logic               rsv19;      // 19
        logic               edge_only;  // 18
        logic               os_en;      // 17
        logic               usr_en;     // 16
        logic [UMASK_W-1:0] umask;      // 15:8
        logic [7:0]         code;       // 7:0
    } evsel_t;
endpackage

// File: rtl/evb_timestamp.sv
// Free-running cycle counter; starts from zero at reset and has no write path.
module evb_timestamp #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    // Advance by one on every clock outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= value + W'(1);
    end
endmodule

// File: rtl/evb_event_qual.sv
// Turns the event inputs into a per-cycle increment for one counter.
// Assumes the sub-event bus per event is as wide as the unit mask.
module evb_event_qual
    import evb_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int INC_W   = $clog2(UMASK_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  evsel_t                     sel,
    input  logic [NUM_EVT-1:0]         evt_fire,
    input  logic [NUM_EVT*UMASK_W-1:0] evt_sub,
    input  logic                       priv_user,
    output logic [INC_W-1:0]           inc
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic               hit;
    logic [IDX_W-1:0]   idx;
    logic               fire_sel;
    logic [UMASK_W-1:0] sub_sel;
    logic [INC_W-1:0]   raw_cnt;
    logic               live;
    logic               thr_set;
    logic               cond;
    logic               prev_cond;

    // Pick the selected event and its sub-event bits.
    always_comb begin
        hit      = int'(sel.code) < NUM_EVT;
        idx      = sel.code[IDX_W-1:0];
        fire_sel = hit && evt_fire[idx];
        sub_sel  = hit ? evt_sub[idx*UMASK_W +: UMASK_W] : '0;
    end

    // Per-cycle event count: strobe, or masked sub-event population.
    always_comb begin
        raw_cnt = '0;
        if (sel.umask == '0) begin
            raw_cnt = INC_W'(fire_sel);
        end else begin
            for (int b = 0; b < UMASK_W; b++)
                raw_cnt = raw_cnt + INC_W'(sub_sel[b] & sel.umask[b]);
        end
    end

    // Qualify by enable, privilege and threshold.
    always_comb begin
        live    = sel.enable && ((sel.usr_en && priv_user) || (sel.os_en && !priv_user));
        thr_set = sel.thresh != '0;
        if (thr_set) cond = live && ((THR_W'(raw_cnt) >= sel.thresh) ^ sel.invert);
        else         cond = live && (raw_cnt != '0);
    end

    // Remember last cycle's condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cond <= 1'b0;
        else        prev_cond <= cond;
    end

    // Final increment by mode.
    always_comb begin
        if (sel.edge_only)  inc = INC_W'(cond && !prev_cond);
        else if (thr_set)   inc = INC_W'(cond);
        else if (live)      inc = raw_cnt;
        else                inc = '0;
    end
endmodule

// File: rtl/evb_counter.sv
// One wrap-around counter with a software write port and a wrap pulse.
// Assumes a write in a cycle wins over that cycle's increment.
module evb_counter #(
    parameter int W     = 48,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     value,
    output logic             wrap
);
    logic [W:0] sum;

    // Add with one bit of headroom to see the carry out.
    always_comb begin
        sum  = {1'b0, value} + (W+1)'(inc);
        wrap = sum[W] && !wr;
    end

    // Load on write, otherwise accumulate modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)  value <= '0;
        else if (wr) value <= wdata;
        else         value <= sum[W-1:0];
    end
endmodule

// File: rtl/evt_counter_bank.sv
// Bank of qualified event counters, selection registers, pending status and
// a timestamp behind one flat register port. Reads are combinational.
// Assumes the requester holds reg_addr stable while sampling reg_rdata.
module evt_counter_bank
    import evb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 8,
    parameter int CTR_W   = 48,
    parameter int TS_W    = 64,
    parameter int ADDR_W  = $clog2(2*NUM_CTR + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [TS_W-1:0]            reg_wdata,
    output logic [TS_W-1:0]            reg_rdata,
    input  logic [NUM_EVT-1:0]         evt_fire,
    input  logic [NUM_EVT*UMASK_W-1:0] evt_sub,
    input  logic                       priv_user,
    output logic                       irq
);
    localparam int INC_W     = $clog2(UMASK_W + 1);
    localparam int TS_ADDR   = 0;
    localparam int CTR_BASE  = 1;
    localparam int SEL_BASE  = CTR_BASE + NUM_CTR;
    localparam int STAT_ADDR = SEL_BASE + NUM_CTR;

    evsel_t             evsel_q [NUM_CTR];
    logic [CTR_W-1:0]   ctr_val [NUM_CTR];
    logic [NUM_CTR-1:0] status_q, status_d;
    logic [NUM_CTR-1:0] wrap_vec, wr_ctr, ie_vec, en_vec, priv_none_vec;
    logic [NUM_CTR*CTR_W-1:0] ctr_flat;
    logic [NUM_CTR*INC_W-1:0] inc_flat;
    logic [TS_W-1:0]    ts_val;
    logic               stat_wr;

    evb_timestamp #(.W(TS_W)) u_ts (.clk(clk), .rst_n(rst_n), .value(ts_val));

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_ctr
            logic [INC_W-1:0] inc;

            assign wr_ctr[g]        = reg_wr && (reg_addr == ADDR_W'(CTR_BASE + g));
            assign ie_vec[g]        = evsel_q[g].irq_en;
            assign en_vec[g]        = evsel_q[g].enable;
            assign priv_none_vec[g] = !evsel_q[g].usr_en && !evsel_q[g].os_en;
            assign ctr_flat[g*CTR_W +: CTR_W] = ctr_val[g];
            assign inc_flat[g*INC_W +: INC_W] = inc;

            evb_event_qual #(.NUM_EVT(NUM_EVT), .INC_W(INC_W)) u_qual (
                .clk(clk), .rst_n(rst_n), .sel(evsel_q[g]),
                .evt_fire(evt_fire), .evt_sub(evt_sub),
                .priv_user(priv_user), .inc(inc)
            );

            evb_counter #(.W(CTR_W), .INC_W(INC_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .inc(inc), .wr(wr_ctr[g]),
                .wdata(reg_wdata[CTR_W-1:0]), .value(ctr_val[g]),
                .wrap(wrap_vec[g])
            );
        end
    endgenerate

    assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

    // Selection registers: plain storage written by address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CTR; i++) begin
            if (!rst_n)
                evsel_q[i] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(SEL_BASE + i))
                evsel_q[i] <= evsel_t'(reg_wdata[SEL_W-1:0]);
        end
    end

    // Pending status: write-one-to-clear, a new wrap takes priority.
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++)
            status_d[i] = (status_q[i] && !(stat_wr && reg_wdata[i]))
                        || (wrap_vec[i] && ie_vec[i]);
    end

    // Register the pending status.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign irq = |status_q;

    // Read mux over the flat register map.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(TS_ADDR))   reg_rdata = ts_val;
        if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = TS_W'(status_q);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(CTR_BASE + i)) reg_rdata = TS_W'(ctr_val[i]);
            if (reg_addr == ADDR_W'(SEL_BASE + i)) reg_rdata = TS_W'(evsel_q[i]);
        end
    end
endmodule

// File: rtl/evb_checker.sv
// Temporal checks on the event counter bank, attached by bind.
module evb_checker #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int INC_W   = 4,
    parameter int TS_W    = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [TS_W-1:0]          ts_val,
    input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
    input logic [NUM_CTR*INC_W-1:0] inc_flat,
    input logic [NUM_CTR-1:0]       wrap_vec,
    input logic [NUM_CTR-1:0]       ie_vec,
    input logic [NUM_CTR-1:0]       en_vec,
    input logic [NUM_CTR-1:0]       priv_none_vec,
    input logic [NUM_CTR-1:0]       wr_ctr,
    input logic [NUM_CTR-1:0]       status_q,
    input logic [TS_W-1:0]          reg_wdata
);
    logic armed;

    // Marks cycles where the previous sample was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_ts_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ts_val == $past(ts_val) + TS_W'(1));

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_chk
            assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
                armed && !$past(en_vec[g]) && !$past(wr_ctr[g])
                |-> $stable(ctr_flat[g*CTR_W +: CTR_W]));

            assert_no_priv_no_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
                priv_none_vec[g] |-> inc_flat[g*INC_W +: INC_W] == '0);

            assert_wrap_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wrap_vec[g] && ie_vec[g] |=> status_q[g]);

            assert_pending_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $rose(status_q[g]) |-> $past(wrap_vec[g] && ie_vec[g]));

            assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
                armed && $past(wr_ctr[g])
                |-> ctr_flat[g*CTR_W +: CTR_W] == $past(reg_wdata[CTR_W-1:0]));
        end
    endgenerate
endmodule

bind evt_counter_bank evb_checker #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .INC_W(INC_W), .TS_W(TS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ts_val(ts_val), .ctr_flat(ctr_flat),
    .inc_flat(inc_flat), .wrap_vec(wrap_vec), .ie_vec(ie_vec),
    .en_vec(en_vec), .priv_none_vec(priv_none_vec), .wr_ctr(wr_ctr),
    .status_q(status_q), .reg_wdata(reg_wdata)
);

// File: tb/evt_counter_bank_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module evt_counter_bank_bench;
    localparam int TS = 0, CTR0 = 1, SEL0 = 5, STAT = 9;
    localparam logic [63:0] TOP48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  evt_fire = '0;
    logic [63:0] evt_sub = '0;
    logic        priv_user = 1;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_counter_bank u_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_fire(evt_fire),
        .evt_sub(evt_sub), .priv_user(priv_user), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Caller is at a negative edge; write commits at the next positive edge.
    task automatic wr_reg(input int a, input logic [63:0] d);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input int a, output logic [63:0] d);
        reg_addr = 4'(a); #1; d = reg_rdata;
    endtask

    function automatic logic [63:0] mk(input logic [7:0] code, input logic [7:0] um,
        input bit usr, input bit os, input bit edg, input bit ie, input bit en,
        input bit inv, input logic [7:0] thr);
        return {32'd0, thr, inv, en, 1'b0, ie, 1'b0, edg, os, usr, um, code};
    endfunction

    task automatic fire(input int idx, input int n);
        evt_fire[idx] = 1;
        repeat (n) @(negedge clk);
        evt_fire[idx] = 0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr_reg(SEL0 + i, 0);
        wr_reg(STAT, 64'hF);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd_reg(TS, d);   chk("R11 timestamp after reset", d, 0);
        chk("R11 irq after reset", 64'(irq), 0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(CTR0 + i, d); chk("R11 counter", d, 0);
            rd_reg(SEL0 + i, d); chk("R11 select", d, 0);
        end
        rd_reg(STAT, d); chk("R11 status", d, 0);
        @(negedge clk);
    endtask

    task automatic t_timestamp();
        logic [63:0] a, b, c;
        rd_reg(TS, a);
        wr_reg(TS, 0);
        rd_reg(TS, b); chk("R1 step and ignored write", b, a + 1);
        repeat (10) @(negedge clk);
        rd_reg(TS, c); chk("R1 ten cycles", c, b + 10);
    endtask

    task automatic t_basic();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 0, 1, 1, 0, 0, 1, 0, 0));
        wr_reg(CTR0, 0);
        fire(2, 5);
        rd_reg(CTR0, d); chk("R3 selected event counted", d, 5);
        fire(5, 3);
        rd_reg(CTR0, d); chk("R3 other event ignored", d, 5);
        wr_reg(SEL0, mk(2, 0, 1, 1, 0, 0, 0, 0, 0));
        fire(2, 3);
        rd_reg(CTR0, d); chk("R2 frozen when disabled", d, 5);
        wr_reg(SEL0, mk(9, 0, 1, 1, 0, 0, 1, 0, 0));
        evt_fire = 8'hFF; repeat (3) @(negedge clk); evt_fire = 0;
        rd_reg(CTR0, d); chk("R3 out-of-range code", d, 5);
        wr_reg(SEL0, 0);
    endtask

    task automatic t_umask();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 8'h0F, 1, 1, 0, 0, 1, 0, 0));
        wr_reg(CTR0, 0);
        evt_sub[23:16] = 8'hFF; repeat (3) @(negedge clk); evt_sub = 0;
        rd_reg(CTR0, d); chk("R4 masked population", d, 12);
        wr_reg(SEL0, mk(2, 8'hF0, 1, 1, 0, 0, 1, 0, 0));
        evt_fire[2] = 1; evt_sub[23:16] = 8'h5A; repeat (2) @(negedge clk);
        evt_sub = 0; evt_fire = 0;
        rd_reg(CTR0, d); chk("R4 strobe unused with mask", d, 16);
        wr_reg(SEL0, 0);
    endtask

    task automatic t_priv();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 0, 1, 0, 0, 0, 1, 0, 0));
        wr_reg(CTR0, 0);
        priv_user = 0; fire(2, 3);
        rd_reg(CTR0, d); chk("R5 user-only at kernel", d, 0);
        priv_user = 1; fire(2, 3);
        rd_reg(CTR0, d); chk("R5 user-only at user", d, 3);
        wr_reg(SEL0, mk(2, 0, 0, 1, 0, 0, 1, 0, 0));
        fire(2, 2);
        rd_reg(CTR0, d); chk("R5 kernel-only at user", d, 3);
        priv_user = 0; fire(2, 2);
        rd_reg(CTR0, d); chk("R5 kernel-only at kernel", d, 5);
        wr_reg(SEL0, mk(2, 0, 0, 0, 0, 0, 1, 0, 0));
        fire(2, 2); priv_user = 1; fire(2, 2);
        rd_reg(CTR0, d); chk("R5 both clear", d, 5);
        wr_reg(SEL0, 0);
    endtask

    task automatic t_thresh();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 8'hFF, 1, 1, 0, 0, 1, 0, 3));
        wr_reg(CTR0, 0);
        evt_sub[23:16] = 8'h07; repeat (2) @(negedge clk);
        evt_sub[23:16] = 8'h03; repeat (2) @(negedge clk);
        evt_sub[23:16] = 8'h0F; @(negedge clk);
        evt_sub = 0;
        rd_reg(CTR0, d); chk("R6 at-least threshold", d, 3);
        wr_reg(SEL0, 0);
        evt_sub[23:16] = 8'h07;
        wr_reg(SEL0, mk(2, 8'hFF, 1, 1, 0, 0, 1, 1, 3));
        wr_reg(CTR0, 0);
        evt_sub[23:16] = 8'h03; repeat (2) @(negedge clk);
        evt_sub[23:16] = 8'h07; repeat (2) @(negedge clk);
        rd_reg(CTR0, d); chk("R6 inverted threshold", d, 2);
        wr_reg(SEL0, 0);
        evt_sub = 0;
    endtask

    task automatic t_edge();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 0, 1, 1, 1, 0, 1, 0, 0));
        wr_reg(CTR0, 0);
        fire(2, 4); @(negedge clk);
        rd_reg(CTR0, d); chk("R7 held level counts once", d, 1);
        fire(2, 1); @(negedge clk); fire(2, 1); @(negedge clk);
        rd_reg(CTR0, d); chk("R7 two rising edges", d, 3);
        wr_reg(SEL0, 0);
    endtask

    task automatic t_sample();
        logic [63:0] d;
        clear_all();
        wr_reg(SEL0, mk(2, 0, 1, 1, 0, 1, 1, 0, 0));
        wr_reg(CTR0, (TOP48 + 1) - 5);
        for (int k = 1; k <= 5; k++) begin
            fire(2, 1);
            chk("R10 irq on N-th event", 64'(irq), 64'(k == 5));
        end
        rd_reg(CTR0, d); chk("R8 wrap to zero", d, 0);
        rd_reg(STAT, d); chk("R8 pending bit", d, 1);
        wr_reg(SEL0, 0);
        wr_reg(STAT, 1);
        wr_reg(SEL0 + 2, mk(2, 0, 1, 1, 0, 0, 1, 0, 0));
        wr_reg(CTR0 + 2, TOP48);
        fire(2, 1);
        rd_reg(CTR0 + 2, d); chk("R8 wrap without irq enable", d, 0);
        rd_reg(STAT, d);     chk("R8 no pending without irq enable", d, 0);
        wr_reg(SEL0 + 2, 0);
    endtask

    task automatic t_pending();
        logic [63:0] d;
        wr_reg(SEL0,     mk(2, 0, 1, 1, 0, 1, 1, 0, 0));
        wr_reg(SEL0 + 1, mk(2, 0, 1, 1, 0, 1, 1, 0, 0));
        wr_reg(CTR0, TOP48);
        wr_reg(CTR0 + 1, TOP48);
        fire(2, 1);
        rd_reg(STAT, d); chk("R9 two pending", d, 3);
        wr_reg(STAT, 1);
        rd_reg(STAT, d); chk("R9 one cleared", d, 2);
        chk("R9 irq still high", 64'(irq), 1);
        wr_reg(SEL0, 0);
        wr_reg(CTR0 + 1, TOP48);
        evt_fire[2] = 1; reg_addr = 4'(STAT); reg_wdata = 2; reg_wr = 1;
        @(negedge clk);
        evt_fire = 0; reg_wr = 0;
        rd_reg(STAT, d); chk("R9 wrap beats clear", d, 2);
        wr_reg(STAT, 2);
        chk("R9 irq low after last clear", 64'(irq), 0);
        wr_reg(SEL0 + 1, 0);
    endtask

    task automatic t_write_wins();
        logic [63:0] d;
        wr_reg(SEL0, mk(2, 0, 1, 1, 0, 0, 1, 0, 0));
        wr_reg(CTR0, 0);
        evt_fire[2] = 1;
        repeat (2) @(negedge clk);
        wr_reg(CTR0, 100);
        evt_fire = 0;
        rd_reg(CTR0, d); chk("R12 write overrides event", d, 100);
        wr_reg(SEL0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timestamp();
        t_basic();
        t_umask();
        t_priv();
        t_thresh();
        t_edge();
        t_sample();
        t_pending();
        t_write_wins();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule